// File: doc/BRIEF.md
# Fixed Off-Time PWM Chopper with Automatic Decay Selection

This block regulates the current in one winding of a bipolar motor bridge. Each chopping cycle starts by switching the bridge into drive. For a short blanking window the current-trip comparator cannot end the on-phase, because switching spikes would trip it falsely. Once blanking is over, a trip ends the on-phase. The bridge then recirculates the winding current for an off period of fixed length, and after that a new on-phase begins. Every duration comes from a cycle counter, so the block needs no analog timing parts.

The decay style of each off period depends on a flag from the step translator. The flag is low when the last step raised the target current, and the off period then uses slow decay throughout. The flag is high when the last step lowered the target current. The off period then starts in fast decay for 31.25% of its length and uses slow decay for the remainder.

Slow decay uses synchronous rectification: both low-side switches are actively turned on. The flag is captured when an off period starts. An enable input blanks the bridge without disturbing the timing. A sleep input blanks the bridge and parks the controller.

Top module: `chop_ctrl`

## Requirements
- R1: While `rst` is high the bridge code is 2'b00 (all switches off) and the controller is idle. After reset is released with `sleep` low, an on-phase begins on the following clock.
- R2: The `bridge` codes are 2'b00 all off, 2'b01 drive, 2'b10 fast decay and 2'b11 slow decay. Slow decay turns on both low-side switches.
- R3: Every on-phase begins with exactly BLANK_CYC cycles of drive. During this window, `trip` on any cycle except the last one has no effect.
- R4: If `trip` is high on the last blanking cycle, the next cycle is already the first cycle of an off period.
- R5: After blanking, drive continues until `trip` is high. The off period then starts on the next cycle.
- R6: Each off period lasts exactly OFF_CYC cycles and is followed directly by a new on-phase with blanking.
- R7: If `decrease` is low on the cycle that starts an off period, all OFF_CYC cycles of that period are slow decay.
- R8: If `decrease` is high on that cycle, the off period gives FAST_CYC cycles of fast decay and then OFF_CYC-FAST_CYC cycles of slow decay. FAST_CYC defaults to OFF_CYC*5/16.
- R9: A change of `decrease` inside an off period does not change that period's decay pattern.
- R10: While `enable` is low, `bridge` reads 2'b00 in the same cycle. The cycle timing keeps running, so the code that reappears when `enable` returns high follows the undisturbed schedule.
- R11: While `sleep` is high, `bridge` reads 2'b00 at once, the controller is held idle and `trip` is ignored. After release, a fresh on-phase with full blanking starts on the next clock, even if sleep interrupted an off period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | High enables the bridge outputs |
| sleep | input | 1 | High parks the controller with the outputs off |
| trip | input | 1 | Current-trip comparator result |
| decrease | input | 1 | High when the latest step lowered the phase current |
| bridge | output | 2 | Bridge mode code |

## Verification
The bench uses a short configuration: an off period of 16 cycles, 5 fast cycles and 4 blanking cycles. It checks the bridge code on every cycle, so every run length is measured exactly. A trip held high during the early blanking cycles must not cut the on-phase short; a design that ignored blanking would leave drive early. A trip still high when blanking ends must lead straight into decay, so a design that demands a fresh trip edge would stay in drive. The decay flag is toggled in the middle of an off period; a design that passes the flag through live would change decay style mid-period. Sleep is asserted during an off period; a design that resumed the old off timer after release would show decay instead of a full blanking window.

// File: rtl/chop_pkg.sv
package chop_pkg;

    typedef enum logic [1:0] {
        BR_OFF   = 2'b00,
        BR_DRIVE = 2'b01,
        BR_FAST  = 2'b10,
        BR_SLOW  = 2'b11
    } bridge_t;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_BLANK = 3'd1,
        ST_ON    = 3'd2,
        ST_FAST  = 3'd3,
        ST_SLOW  = 3'd4
    } chop_state_t;

    function automatic bridge_t state_to_bridge(input chop_state_t s);
        case (s)
            ST_BLANK, ST_ON: return BR_DRIVE;
            ST_FAST:         return BR_FAST;
            ST_SLOW:         return BR_SLOW;
            default:         return BR_OFF;
        endcase
    endfunction

endpackage

// File: rtl/chop_timer.sv
module chop_timer #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    always_ff @(posedge clk) begin
        if (rst || restart)
            cnt <= '0;
        else if (cnt != CNT_MAX)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/chop_fsm.sv
module chop_fsm
    import chop_pkg::*;
#(
    parameter int OFF_CYC   = 960,
    parameter int FAST_CYC  = 300,
    parameter int BLANK_CYC = 32,
    parameter int CW        = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sleep,
    input  logic          trip,
    input  logic          decrease,
    input  logic [CW-1:0] cnt,
    output logic          restart,
    output chop_state_t   state
);
    localparam logic [CW-1:0] BLANK_LAST = CW'(BLANK_CYC - 1);
    localparam logic [CW-1:0] FAST_LAST  = CW'(FAST_CYC - 1);
    localparam logic [CW-1:0] OFF_LAST   = CW'(OFF_CYC - 1);

    chop_state_t nxt;
    chop_state_t off_entry;

    always_comb begin
        off_entry = decrease ? ST_FAST : ST_SLOW;
        nxt = state;
        case (state)
            ST_IDLE:  nxt = ST_BLANK;
            ST_BLANK: if (cnt == BLANK_LAST) nxt = trip ? off_entry : ST_ON;
            ST_ON:    if (trip) nxt = off_entry;
            ST_FAST:  if (cnt == FAST_LAST) nxt = ST_SLOW;
            ST_SLOW:  if (cnt == OFF_LAST) nxt = ST_BLANK;
            default:  nxt = ST_IDLE;
        endcase
        if (sleep) nxt = ST_IDLE;
        // the fast-to-slow hand-over keeps counting: one off period, one timer run
        restart = (nxt != state) && !(state == ST_FAST && nxt == ST_SLOW);
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    // R3: early blanking cycles keep the bridge in drive regardless of trip
    p_blank_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BLANK && cnt != BLANK_LAST && !sleep) |=> state == ST_BLANK);

    // R5: a trip during the on-phase starts an off period next cycle
    p_trip_ends_on_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ON && trip && !sleep) |=> (state == ST_FAST || state == ST_SLOW));

    // R6: slow decay persists until the off period is used up
    p_off_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SLOW && cnt != OFF_LAST && !sleep) |=> state == ST_SLOW);

    // R8: a decrease flag at off entry selects fast decay first
    p_mixed_pick_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ON && trip && decrease && !sleep) |=> state == ST_FAST);

    // R8: fast portion hands over to slow decay, never back to drive
    p_fast_to_slow_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FAST && cnt == FAST_LAST && !sleep) |=> state == ST_SLOW);

    // R11: sleep parks the controller
    p_sleep_idle_r11: assert property (@(posedge clk) disable iff (rst)
        sleep |=> state == ST_IDLE);
endmodule

// File: rtl/chop_ctrl.sv
module chop_ctrl
    import chop_pkg::*;
#(
    parameter int OFF_CYC   = 960,
    parameter int FAST_CYC  = OFF_CYC * 5 / 16,
    parameter int BLANK_CYC = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       sleep,
    input  logic       trip,
    input  logic       decrease,
    output logic [1:0] bridge
);
    localparam int CW = $clog2(OFF_CYC + BLANK_CYC + 1);

    logic [CW-1:0] cnt;
    logic          restart;
    chop_state_t   state;

    chop_timer #(.CW(CW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .cnt     (cnt)
    );

    chop_fsm #(
        .OFF_CYC   (OFF_CYC),
        .FAST_CYC  (FAST_CYC),
        .BLANK_CYC (BLANK_CYC),
        .CW        (CW)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .sleep    (sleep),
        .trip     (trip),
        .decrease (decrease),
        .cnt      (cnt),
        .restart  (restart),
        .state    (state)
    );

    always_comb begin
        if (enable && !sleep) bridge = state_to_bridge(state);
        else                  bridge = BR_OFF;
    end

    initial begin
        assert (FAST_CYC >= 1 && FAST_CYC < OFF_CYC && BLANK_CYC >= 1);
    end

    // R1: reset leaves the bridge off on the next cycle
    p_reset_off_r1: assert property (@(posedge clk)
        rst |=> bridge == BR_OFF);
endmodule

// File: tb/sim_chop_ctrl.sv
module sim_chop_ctrl;
    localparam int OFF = 16, FST = 5, BLK = 4;
    localparam logic [1:0] C_OFF = 2'b00, C_DRV = 2'b01, C_FST = 2'b10, C_SLW = 2'b11;

    logic clk = 1'b0, rst = 1'b1, enable = 1'b1, sleep = 1'b0, trip = 1'b0, decrease = 1'b0;
    logic [1:0] bridge;
    int checks = 0, errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    chop_ctrl #(.OFF_CYC(OFF), .FAST_CYC(FST), .BLANK_CYC(BLK)) u0 (
        .clk(clk), .rst(rst), .enable(enable), .sleep(sleep),
        .trip(trip), .decrease(decrease), .bridge(bridge));

    task automatic chk(input logic [1:0] exp, input string tag);
        checks++;
        if (bridge !== exp) begin
            errors++;
            $display("FAIL %s: bridge=%b expected=%b at %0t", tag, bridge, exp, $time);
        end
    endtask

    task automatic run(input logic [1:0] exp, input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(exp, tag);
        end
    endtask

    initial begin
        // R1: reset state
        run(C_OFF, 3, "R1 reset");
        rst = 1'b0;
        trip = 1'b1;                       // R3: trip during early blanking ignored
        run(C_DRV, 3, "R3 blank start");
        trip = 1'b0;
        run(C_DRV, 1, "R3 blank end");
        run(C_DRV, 6, "R5 on holds");
        // R7 slow-only off with R9 flag wiggle
        trip = 1'b1;
        run(C_SLW, 2, "R7 slow");
        decrease = 1'b1;
        run(C_SLW, 5, "R9 flag ignored");
        decrease = 1'b0;
        run(C_SLW, 9, "R6 off length");
        run(C_DRV, 4, "R6 new blank");
        run(C_SLW, 16, "R4 trip at blank end");
        trip = 1'b0;
        run(C_DRV, 10, "R5 on");
        // R8 mixed decay with R9 flag drop
        decrease = 1'b1;
        trip = 1'b1;
        run(C_FST, 1, "R8 fast");
        decrease = 1'b0;
        run(C_FST, 4, "R9 fast kept");
        run(C_SLW, 11, "R8 slow tail");
        trip = 1'b0;
        decrease = 1'b1;
        run(C_DRV, 7, "R6 blank+on");
        trip = 1'b1;
        run(C_FST, 5, "R8 fast again");
        run(C_SLW, 11, "R8 slow again");
        trip = 1'b0;
        decrease = 1'b0;
        run(C_DRV, 6, "R6 on");
        // R10 enable
        enable = 1'b0;
        #1 chk(C_OFF, "R10 immediate off");
        run(C_OFF, 3, "R10 disabled");
        enable = 1'b1;
        #1 chk(C_DRV, "R10 restore");
        trip = 1'b1;
        enable = 1'b0;
        run(C_OFF, 5, "R10 off during decay");
        enable = 1'b1;
        run(C_SLW, 11, "R10 timing kept");
        trip = 1'b0;
        run(C_DRV, 6, "R6 on after");
        // R11 sleep
        sleep = 1'b1;
        #1 chk(C_OFF, "R11 immediate off");
        trip = 1'b1;
        run(C_OFF, 5, "R11 asleep");
        sleep = 1'b0;
        run(C_DRV, 4, "R11 fresh blank");
        run(C_SLW, 1, "R4 after wake");
        sleep = 1'b1;
        #1 chk(C_OFF, "R11 sleep in off");
        run(C_OFF, 3, "R11 asleep off");
        sleep = 1'b0;
        trip = 1'b0;
        run(C_DRV, 6, "R11 restart on");
        // R2: codes exercised above: 00 off, 01 drive, 10 fast, 11 slow
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: bench hung, actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule